// File: doc/BRIEF.md
# Aging Four-Class Link Slot Arbiter

This block decides which of four outbound link traffic classes gets the single transmit slot in a given cycle. The four classes are flow-control idle packets, non-posted requests, responses and posted requests. Each class raises a request bit and receives a grant bit. The block also reports the binary index of the winner. The grant is formed combinationally in the same cycle as the requests.

Each class carries a 4-bit effective priority, where a smaller value is more urgent. The value starts from a programmable field in a 16-bit configuration word. While a class requests without being served, its value steps toward zero at a fixed cycle interval. Once the class is served, its value is reloaded from the configuration word. A class that is waiting long enough therefore overtakes classes that were set up as more urgent. A fixed order among classes breaks ties.

Top module: `aging_arbiter`

## Requirements
- R1: At most one grant bit is high in any cycle. With no request, grant is 0000 and the index is 0. When a grant is given, the index equals the position of the set grant bit.
- R2: The requesting class with the smallest effective priority wins. Out of reset the effective priorities are 4 for idle, 3 for non-posted, 2 for response and 1 for posted.
- R3: Bit positions in req and gnt, and the index values, are: posted 0, response 1, non-posted 2, idle 3. The configuration word holds idle in [15:12], non-posted in [11:8], response in [7:4] and posted in [3:0].
- R4: When requesters share the smallest value, the winner follows a fixed order: response first, then posted, then non-posted, then idle.
- R5: A class that requests and is not granted has its effective priority lowered by one after every AGE_INTERVAL such cycles.
- R6: An effective priority that has reached 0 stays at 0 while the class keeps waiting.
- R7: On the clock after a grant, the granted class's effective priority equals its configuration field. Its aging count restarts.
- R8: A change to the configuration word does not alter any effective priority until that class is next granted.
- R9: A class that does not request keeps its effective priority and its aging count unchanged.
- R10: A grant is only ever given to a class whose request is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prio | input | 4*PRIO_W | Starting priority per class, idle in the top field |
| req | input | 4 | Request per class |
| gnt | output | 4 | One-hot grant, combinational |
| gnt_idx | output | 2 | Index of the granted class |

## Verification
The bench builds the arbiter with AGE_INTERVAL set to 4 and with the default 4-bit priority and 0x4321 reset value. This lets a class starting at 4 age all the way to 0 within sixteen waiting cycles. Every aging step, the tie at value 1 against posted traffic, and the final overtake therefore happen inside a short directed run. Writing zero into the configuration fields drives all classes onto equal values. This exposes the full tie order and the saturation floor with no long waits.

// File: rtl/aging_arbiter_pkg.sv
`timescale 1ns/1ps
package aging_arbiter_pkg;
   localparam int NUM_CLASS = 4;
   localparam int IDX_W     = $clog2(NUM_CLASS);

   // class positions in req/gnt and index encoding
   localparam int CLS_POSTED = 0;
   localparam int CLS_RESP   = 1;
   localparam int CLS_NONPST = 2;
   localparam int CLS_IDLE   = 3;

   // class examined at tie rank r (rank 0 wins ties)
   function automatic int class_at_rank(input int r);
      case (r)
         0:       return CLS_RESP;
         1:       return CLS_POSTED;
         2:       return CLS_NONPST;
         default: return CLS_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/aging_prio_cell.sv
`timescale 1ns/1ps
module aging_prio_cell #(
   parameter int                PRIO_W       = 4,
   parameter int                AGE_INTERVAL = 16,
   parameter logic [PRIO_W-1:0] RESET_VAL    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              gnt,
   input  logic [PRIO_W-1:0] start,
   output logic [PRIO_W-1:0] prio
);
   logic waiting;
   logic tick;

   assign waiting = req & ~gnt;

   generate
      if (AGE_INTERVAL < 1) begin : g_bad_interval
         $error("aging_prio_cell: AGE_INTERVAL must be at least 1");
      end
      if (PRIO_W < 1) begin : g_bad_width
         $error("aging_prio_cell: PRIO_W must be at least 1");
      end

      if (AGE_INTERVAL == 1) begin : g_every_cycle
         assign tick = waiting;
      end else begin : g_counted
         localparam int              CNT_W = $clog2(AGE_INTERVAL);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(AGE_INTERVAL - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (gnt)        cnt <= '0;
            else if (waiting) begin
               if (cnt == LAST)  cnt <= '0;
               else              cnt <= cnt + 1'b1;
            end
         end

         assign tick = waiting && (cnt == LAST);

         assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    prio <= RESET_VAL;
      else if (gnt)                  prio <= start;
      else if (tick && prio != '0)   prio <= prio - 1'b1;
   end

   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |=> prio == $past(start));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(prio));
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && prio == '0) |=> prio == '0);
   assert_age_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && prio != '0) |=> (prio == $past(prio)) || (prio == $past(prio) - 1'b1));
endmodule

// File: rtl/aging_pick.sv
`timescale 1ns/1ps
module aging_pick
   import aging_arbiter_pkg::*;
#(
   parameter int PRIO_W = 4
) (
   input  logic [NUM_CLASS-1:0]        req,
   input  logic [NUM_CLASS*PRIO_W-1:0] prio_flat,
   output logic [NUM_CLASS-1:0]        gnt,
   output logic [IDX_W-1:0]            gnt_idx
);
   always_comb begin
      logic              found;
      logic [PRIO_W-1:0] best;
      logic [PRIO_W-1:0] cand;
      int                win;
      found = 1'b0;
      best  = '1;
      win   = 0;
      for (int r = 0; r < NUM_CLASS; r++) begin
         cand = prio_flat[class_at_rank(r)*PRIO_W +: PRIO_W];
         if (req[class_at_rank(r)] && (!found || cand < best)) begin
            found = 1'b1;
            best  = cand;
            win   = class_at_rank(r);
         end
      end
      gnt     = '0;
      gnt_idx = '0;
      if (found) begin
         gnt[win] = 1'b1;
         gnt_idx  = IDX_W'(win);
      end
   end
endmodule

// File: rtl/aging_arbiter.sv
`timescale 1ns/1ps
module aging_arbiter
   import aging_arbiter_pkg::*;
#(
   parameter int                          PRIO_W       = 4,
   parameter int                          AGE_INTERVAL = 16,
   parameter logic [NUM_CLASS*PRIO_W-1:0] RESET_PRIO   = 16'h4321
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CLASS*PRIO_W-1:0] cfg_prio,
   input  logic [NUM_CLASS-1:0]        req,
   output logic [NUM_CLASS-1:0]        gnt,
   output logic [IDX_W-1:0]            gnt_idx
);
   logic [NUM_CLASS*PRIO_W-1:0] prio_flat;

   generate
      for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cell
         aging_prio_cell #(
            .PRIO_W       (PRIO_W),
            .AGE_INTERVAL (AGE_INTERVAL),
            .RESET_VAL    (RESET_PRIO[c*PRIO_W +: PRIO_W])
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[c]),
            .gnt   (gnt[c]),
            .start (cfg_prio[c*PRIO_W +: PRIO_W]),
            .prio  (prio_flat[c*PRIO_W +: PRIO_W])
         );
      end
   endgenerate

   aging_pick #(.PRIO_W(PRIO_W)) u_pick (
      .req       (req),
      .prio_flat (prio_flat),
      .gnt       (gnt),
      .gnt_idx   (gnt_idx)
   );

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (gnt == '0 && gnt_idx == '0));
   assert_idx_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> gnt[gnt_idx]);
   assert_grant_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   assert_some_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (gnt != '0));
endmodule

// File: tb/aging_arbiter_test.sv
`timescale 1ns/1ps
module aging_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_prio = 16'h4321;
   logic [3:0]  req = 4'b0000;
   logic [3:0]  gnt;
   logic [1:0]  gnt_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   aging_arbiter #(.PRIO_W(4), .AGE_INTERVAL(4), .RESET_PRIO(16'h4321)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_prio(cfg_prio),
      .req(req), .gnt(gnt), .gnt_idx(gnt_idx));

   // {req, expected gnt, expected idx}, each applied from a fresh reset
   localparam logic [9:0] VEC [7] = '{
      {4'b0000, 4'b0000, 2'd0},   // R1 nothing requested
      {4'b1111, 4'b0001, 2'd0},   // R2 posted at 1 is best
      {4'b1110, 4'b0010, 2'd1},   // R2 response at 2
      {4'b1100, 4'b0100, 2'd2},   // R2 non-posted at 3
      {4'b1000, 4'b1000, 2'd3},   // R3 idle alone, index 3
      {4'b1010, 4'b0010, 2'd1},   // R2 response beats idle
      {4'b0101, 4'b0001, 2'd0}    // R10 only requesters considered
   };

   task automatic do_reset();
      rst_n = 1'b0;
      req   = 4'b0000;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive at a falling edge, sample 1 ns later, end on the next falling edge
   task automatic cyc(input logic [3:0] r, input logic [3:0] eg,
                      input logic [1:0] ei, input string tag);
      req = r;
      #1;
      checks++;
      if (gnt !== eg || gnt_idx !== ei) begin
         fails++;
         $display("FAIL %s req=%b actual gnt=%b idx=%0d expected gnt=%b idx=%0d",
                  tag, r, gnt, gnt_idx, eg, ei);
      end
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      cyc(4'b0000, 4'b0000, 2'd0, "R1 reset state");

      foreach (VEC[i]) begin
         do_reset();
         cyc(VEC[i][9:6], VEC[i][5:2], VEC[i][1:0], "R1/R2/R3/R10 table");
      end

      // R5 aging: idle 4 waits behind posted 1; ties at 1 go to posted (R4)
      do_reset();
      for (int k = 0; k < 16; k++) cyc(4'b1001, 4'b0001, 2'd0, "R5 posted ahead while idle ages");
      cyc(4'b1001, 4'b1000, 2'd3, "R5 idle reaches 0 and overtakes");
      cyc(4'b1001, 4'b0001, 2'd0, "R7 idle reloaded to 4");

      // R9 non-requesting classes do not age
      do_reset();
      for (int k = 0; k < 20; k++) cyc(4'b0001, 4'b0001, 2'd0, "R9 posted alone");
      cyc(4'b1100, 4'b0100, 2'd2, "R9 idle held at 4, non-posted 3 wins");

      // R8 config change does not disturb live values
      do_reset();
      cfg_prio = 16'h0321;
      cyc(4'b1100, 4'b0100, 2'd2, "R8 idle still 4 after config write");
      cyc(4'b1000, 4'b1000, 2'd3, "R8 idle alone");
      cyc(4'b1100, 4'b1000, 2'd3, "R7 idle reloaded to new field 0");

      // R4 tie order with every class at 0
      do_reset();
      cfg_prio = 16'h0000;
      cyc(4'b0001, 4'b0001, 2'd0, "R3 posted alone");
      cyc(4'b0010, 4'b0010, 2'd1, "R3 response alone");
      cyc(4'b0100, 4'b0100, 2'd2, "R3 non-posted alone");
      cyc(4'b1000, 4'b1000, 2'd3, "R3 idle alone");
      cyc(4'b1111, 4'b0010, 2'd1, "R4 response first");
      cyc(4'b1101, 4'b0001, 2'd0, "R4 posted second");
      cyc(4'b1100, 4'b0100, 2'd2, "R4 non-posted before idle");

      // R6 saturation: non-posted at 1, idle waits at 0 behind response
      cfg_prio = 16'h0100;
      cyc(4'b0100, 4'b0100, 2'd2, "R7 non-posted reloaded to 1");
      for (int k = 0; k < 10; k++) cyc(4'b1010, 4'b0010, 2'd1, "R4 response beats idle at 0");
      cyc(4'b1100, 4'b1000, 2'd3, "R6 idle held at 0, beats non-posted 1");

      cyc(4'b0000, 4'b0000, 2'd0, "R1 no request");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1-side run did not finish actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule